// File: doc/BRIEF.md
# Multicycle Five-Phase Load/Store Core

This block is a small, non-pipelined processor with its own instruction store and data store. Every instruction is a 32-bit word and passes through five phases, one clock each. In order, these are: fetch into the instruction register, operand read from a 32-entry file of 16-bit registers, ALU evaluation, data-store access, and result write-back with program-counter update. A central sequencer decodes the held instruction word. It then steers the program-counter source, the ALU second-operand source, the ALU function, the data-store write strobe, the destination-register select and the write-back source.

The instruction store is filled through a simple write port, normally while the core is held in reset. Three kinds of activity are visible at the ports: the current instruction address and phase, the register write-back bus, and the data-store write bus. These let an integrator or a test follow execution instruction by instruction.

Top module: `rcore_top`

## Requirements
- R1: While reset is held and in the first cycle after release, `pc_o` is 0, `phase_o` is 0, and `rf_we_o` and `dm_we_o` are low. All 32 registers read as zero after reset.
- R2: `phase_o` steps 0 (fetch), 1 (operand read), 2 (execute), 3 (memory), 4 (write-back), then back to 0, one cycle per phase, for every instruction. `pc_o` holds the address of the current instruction through all five phases and changes only at the end of phase 4. `rf_we_o` may be high only in phase 4, and `dm_we_o` only in phase 3.
- R3: Opcode 0x00 (bits 31:26) is register type, with rs in bits 25:21, rt in 20:16, rd in 15:11 and function in 5:0. Function 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs, 0x25 ORs and 0x26 XORs, all modulo 2^16. The result is written to rd in phase 4.
- R4: Opcode 0x08 writes rs plus the 16-bit immediate in bits 15:0, modulo 2^16, to rt.
- R5: Register 0 always reads as zero. A write addressed to it is shown on the write-back bus but has no effect.
- R6: Opcode 0x2B (store) raises `dm_we_o` in phase 3. It drives `dm_addr_o` with the low 6 bits of rs plus the immediate and `dm_wdata_o` with rt. It performs no register write.
- R7: Opcode 0x23 (load) writes to rt the data word at the low 6 bits of rs plus the immediate. A load never raises `dm_we_o`.
- R8: Opcode 0x02 (jump) sets the next address to four times the low 6 bits of the 26-bit target field in bits 25:0. It performs no write.
- R9: Opcode 0x04 (branch if equal) sets the next address to the current address plus four times the sign-extended immediate when rs equals rt. Otherwise the next address is the current address plus 4. Both are taken modulo 256, and the branch performs no write.
- R10: Any other opcode, and a register-type word with any other function code, performs no register or data write and advances the address by 4.
- R11: A high `imem_we` writes `imem_wdata` into instruction word `imem_waddr`. Fetch reads word `pc_o`/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction-store write strobe |
| imem_waddr | input | 6 | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| pc_o | output | 8 | Byte address of the current instruction |
| phase_o | output | 3 | Current phase, 0 to 4 |
| rf_we_o | output | 1 | Register write in this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 16 | Value written back |
| dm_we_o | output | 1 | Data-store write in this cycle |
| dm_addr_o | output | 6 | Data-store word address |
| dm_wdata_o | output | 16 | Data-store write value |

## Verification
A wrong register value stays hidden until a later instruction reads that register. It then shows as a wrong value on the write-back bus or the store bus, five cycles or more after the faulty write. The checks therefore chain writes, reads and stores within short programs. A mis-selected next address shows at the following fetch as a wrong `pc_o`. A wrong write-back source or destination select shows in phase 4 of the same instruction, and a phase-counter fault shows within one cycle on `phase_o`.

// File: rtl/rcore_pkg.sv
// Shared types for the multicycle core: phase encoding, ALU functions,
// next-address sources, the decoded control word and the instruction
// field codes. Assumes 32-bit instruction words with 5-bit register fields.
package rcore_pkg;

    localparam int INSN_W = 32;
    localparam int RA_W   = 5;

    typedef enum logic [2:0] {
        PH_IF  = 3'd0,
        PH_ID  = 3'd1,
        PH_EX  = 3'd2,
        PH_MEM = 3'd3,
        PH_WB  = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4
    } alu_fn_t;

    typedef enum logic [1:0] {
        NXT_INC = 2'd0,
        NXT_ABS = 2'd1,
        NXT_REL = 2'd2
    } nxt_sel_t;

    typedef struct packed {
        alu_fn_t  alu_fn;
        logic     use_imm;
        logic     reg_wr;
        logic     dst_is_rt;
        logic     mem_rd;
        logic     mem_wr;
        logic     wb_from_mem;
        nxt_sel_t nxt_sel;
    } ctrl_t;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LD   = 6'h23;
    localparam logic [5:0] OPC_ST   = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;

endpackage

// File: rtl/rcore_mem.sv
// Simple storage array: one synchronous write port and one combinational
// read port. No reset; contents are undefined until written.
module rcore_mem #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    // Store the write word at its index.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the addressed word.
    assign rdata = cells[raddr];

endmodule

// File: rtl/rcore_regfile.sv
// Register file: two combinational read ports, one write port.
// Entry 0 is hard-wired to zero; writes to it are dropped.
// All entries clear on synchronous active-low reset.
module rcore_regfile #(
    parameter int W     = 16,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    // Clear on reset, otherwise commit a write to any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports, forcing zero for entry 0.
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rcore_alu.sv
// Combinational ALU for the core: add, subtract, and, or, xor, all
// modulo 2^W. Also flags operand equality for the conditional branch.
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_t       fn,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y,
    output logic          eq
);

    // Select the result for the requested function.
    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end

    // Equality of the raw operands.
    assign eq = (a == b);

endmodule

// File: rtl/rcore_seq.sv
// Control sequencer: a five-state phase counter plus an instruction
// decoder producing the control word for the held instruction.
// Assumes the instruction register is stable from phase 1 to phase 4.
module rcore_seq
    import rcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] ir,
    output phase_t            phase,
    output ctrl_t             ctrl
);

    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = ir[31:26];
    assign fn  = ir[5:0];

    // Advance the phase once per cycle, wrapping after write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IF;
        end else begin
            case (phase)
                PH_IF:   phase <= PH_ID;
                PH_ID:   phase <= PH_EX;
                PH_EX:   phase <= PH_MEM;
                PH_MEM:  phase <= PH_WB;
                default: phase <= PH_IF;
            endcase
        end
    end

    // Decode the opcode and function into datapath controls.
    always_comb begin
        ctrl         = '0;
        ctrl.alu_fn  = ALU_ADD;
        ctrl.nxt_sel = NXT_INC;
        case (opc)
            OPC_REG: begin
                case (fn)
                    FN_ADD: begin ctrl.reg_wr = 1'b1; ctrl.alu_fn = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_wr = 1'b1; ctrl.alu_fn = ALU_SUB; end
                    FN_AND: begin ctrl.reg_wr = 1'b1; ctrl.alu_fn = ALU_AND; end
                    FN_OR:  begin ctrl.reg_wr = 1'b1; ctrl.alu_fn = ALU_OR;  end
                    FN_XOR: begin ctrl.reg_wr = 1'b1; ctrl.alu_fn = ALU_XOR; end
                    default: ;
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_wr    = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
            end
            OPC_LD: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.use_imm     = 1'b1;
                ctrl.dst_is_rt   = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_ST: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_JMP: ctrl.nxt_sel = NXT_ABS;
            OPC_BEQ: begin
                ctrl.alu_fn  = ALU_SUB;
                ctrl.nxt_sel = NXT_REL;
            end
            default: ;
        endcase
    end

    // R2: the phase walks 0..4 and wraps, one step per cycle.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WB) |=> (phase == PH_IF));
    assert_phase_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WB) |=> (phase == phase_t'($past(phase) + 3'd1)));

endmodule

// File: rtl/rcore_top.sv
// Multicycle load/store core top. Holds the program counter, instruction
// register and inter-phase registers, the instruction and data stores,
// and instantiates sequencer, register file and ALU.
// Assumes 32 registers (5-bit fields) and a 16-bit immediate.
module rcore_top
    import rcore_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int XLEN       = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [31:0]                   imem_wdata,
    output logic [$clog2(IMEM_WORDS)+1:0] pc_o,
    output logic [2:0]                    phase_o,
    output logic                          rf_we_o,
    output logic [4:0]                    rf_waddr_o,
    output logic [XLEN-1:0]               rf_wdata_o,
    output logic                          dm_we_o,
    output logic [$clog2(DMEM_WORDS)-1:0] dm_addr_o,
    output logic [XLEN-1:0]               dm_wdata_o
);

    localparam int IA_W  = $clog2(IMEM_WORDS);
    localparam int DA_W  = $clog2(DMEM_WORDS);
    localparam int PC_W  = IA_W + 2;
    localparam int NREGS = 32;

    phase_t             phase;
    ctrl_t              ctrl;
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    pc_next;
    logic [PC_W-1:0]    pc_inc;
    logic [PC_W-1:0]    br_off;
    logic [INSN_W-1:0]  ir;
    logic [INSN_W-1:0]  imem_rd;
    logic [XLEN-1:0]    a_q, b_q, alu_q, mdr;
    logic               eq_q;
    logic [XLEN-1:0]    imm;
    logic [XLEN-1:0]    rf_rd1, rf_rd2;
    logic [XLEN-1:0]    alu_b, alu_y;
    logic               alu_eq;
    logic [XLEN-1:0]    dm_rd;
    logic               rf_we;
    logic [RA_W-1:0]    rf_wa;
    logic [XLEN-1:0]    rf_wd;
    logic               dm_we;

    rcore_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .ir    (ir),
        .phase (phase),
        .ctrl  (ctrl)
    );

    rcore_mem #(.W(INSN_W), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc_q[PC_W-1:2]),
        .rdata (imem_rd)
    );

    rcore_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir[25:21]),
        .ra2   (ir[20:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    rcore_alu #(.W(XLEN)) u_alu (
        .fn (ctrl.alu_fn),
        .a  (a_q),
        .b  (alu_b),
        .y  (alu_y),
        .eq (alu_eq)
    );

    rcore_mem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (alu_q[DA_W-1:0]),
        .wdata (b_q),
        .raddr (alu_q[DA_W-1:0]),
        .rdata (dm_rd)
    );

    // Fit the 16-bit immediate to the datapath width.
    generate
        if (XLEN >= 16) begin : g_imm_ext
            assign imm = {{(XLEN-16){ir[15]}}, ir[15:0]};
        end else begin : g_imm_cut
            assign imm = ir[XLEN-1:0];
        end
    endgenerate

    // Scale the branch offset by four at the address width.
    generate
        if (PC_W - 2 <= 16) begin : g_off_cut
            assign br_off = {ir[PC_W-3:0], 2'b00};
        end else begin : g_off_ext
            assign br_off = {{(PC_W-18){ir[15]}}, ir[15:0], 2'b00};
        end
    endgenerate

    // Second ALU operand: register B or immediate.
    assign alu_b = ctrl.use_imm ? imm : b_q;

    // Next-address multiplexer: increment, absolute target, relative.
    assign pc_inc = pc_q + PC_W'(4);
    always_comb begin
        case (ctrl.nxt_sel)
            NXT_ABS: pc_next = {ir[IA_W-1:0], 2'b00};
            NXT_REL: pc_next = eq_q ? (pc_q + br_off) : pc_inc;
            default: pc_next = pc_inc;
        endcase
    end

    // Phase-gated strobes and write-back selects.
    assign rf_we = (phase == PH_WB) && ctrl.reg_wr;
    assign rf_wa = ctrl.dst_is_rt ? ir[20:16] : ir[15:11];
    assign rf_wd = ctrl.wb_from_mem ? mdr : alu_q;
    assign dm_we = (phase == PH_MEM) && ctrl.mem_wr;

    // Load each inter-phase register in its own phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
            eq_q  <= 1'b0;
            mdr   <= '0;
        end else begin
            case (phase)
                PH_IF:  ir <= imem_rd;
                PH_ID: begin
                    a_q <= rf_rd1;
                    b_q <= rf_rd2;
                end
                PH_EX: begin
                    alu_q <= alu_y;
                    eq_q  <= alu_eq;
                end
                PH_MEM: if (ctrl.mem_rd) mdr <= dm_rd;
                default: pc_q <= pc_next;
            endcase
        end
    end

    assign pc_o       = pc_q;
    assign phase_o    = phase;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = rf_wa;
    assign rf_wdata_o = rf_wd;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_q[DA_W-1:0];
    assign dm_wdata_o = b_q;

    // R2: the instruction address moves only out of write-back.
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 3'd4) |=> $stable(pc_o));
    // R2: register writes only in write-back.
    assert_rf_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (phase_o == 3'd4));
    // R6: store strobe only in the memory phase.
    assert_dm_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> (phase_o == 3'd3));
    // R7: store strobe never coincides with a load's write-back source.
    assert_ld_no_st_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_rd |-> !dm_we_o);
    // R8: a jump never writes a register or the data store.
    assert_jmp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nxt_sel != NXT_INC) |-> (!rf_we_o && !dm_we_o));

endmodule

// File: tb/sim_rcore_top.sv
`timescale 1ns/1ps
module sim_rcore_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [7:0]  pc_o;
    logic [2:0]  phase_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [15:0] rf_wdata_o;
    logic        dm_we_o;
    logic [5:0]  dm_addr_o;
    logic [15:0] dm_wdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] prog [64];
    int plen;

    always #4 clk = ~clk;

    rcore_top u0 (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .pc_o(pc_o), .phase_o(phase_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'h02, t};
    endfunction
    function automatic logic [15:0] alu_ref(int k, logic [15:0] a, logic [15:0] b);
        case (k)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Load prog[0..plen-1] under reset, check reset state, release.
    task automatic boot();
        rst_n = 1'b0;
        for (int k = 0; k < plen; k++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = 6'(k); imem_wdata = prog[k];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        check("R1 reset pc", pc_o, 0);
        check("R1 reset phase", phase_o, 0);
        check("R1 reset strobes", {rf_we_o, dm_we_o}, 0);
        rst_n = 1'b1;
    endtask

    // Run one instruction (five cycles), capturing port activity.
    task automatic step(output logic [7:0] pc, output logic rwe, output logic [4:0] ra,
                        output logic [15:0] rd, output logic dwe, output logic [5:0] da,
                        output logic [15:0] dd);
        pc = pc_o; rwe = 0; ra = 0; rd = 0; dwe = 0; da = 0; dd = 0;
        for (int p = 0; p < 5; p++) begin
            check("R2 phase", phase_o, p);
            if (p > 0) check("R2 pc hold", pc_o, pc);
            if (p != 4) check("R2 no rf write outside wb", rf_we_o, 0);
            if (p != 3) check("R2 no dm write outside mem", dm_we_o, 0);
            if (p == 3) begin dwe = dm_we_o; da = dm_addr_o; dd = dm_wdata_o; end
            if (p == 4) begin rwe = rf_we_o; ra = rf_waddr_o; rd = rf_wdata_o; end
            @(negedge clk);
        end
    endtask

    task automatic exp_wr(string tag, logic [7:0] epc, logic [4:0] ea, logic [15:0] ed);
        logic [7:0] pc; logic rwe; logic [4:0] ra; logic [15:0] rd;
        logic dwe; logic [5:0] da; logic [15:0] dd;
        step(pc, rwe, ra, rd, dwe, da, dd);
        check({tag, " pc"}, pc, epc);
        check({tag, " rf_we"}, rwe, 1);
        check({tag, " rf_waddr"}, ra, ea);
        check({tag, " rf_wdata"}, rd, ed);
        check({tag, " dm_we"}, dwe, 0);
    endtask

    task automatic exp_quiet(string tag, logic [7:0] epc);
        logic [7:0] pc; logic rwe; logic [4:0] ra; logic [15:0] rd;
        logic dwe; logic [5:0] da; logic [15:0] dd;
        step(pc, rwe, ra, rd, dwe, da, dd);
        check({tag, " pc"}, pc, epc);
        check({tag, " no writes"}, {rwe, dwe}, 0);
    endtask

    task automatic exp_st(string tag, logic [7:0] epc, logic [5:0] ea, logic [15:0] ed);
        logic [7:0] pc; logic rwe; logic [4:0] ra; logic [15:0] rd;
        logic dwe; logic [5:0] da; logic [15:0] dd;
        step(pc, rwe, ra, rd, dwe, da, dd);
        check({tag, " pc"}, pc, epc);
        check({tag, " rf_we"}, rwe, 0);
        check({tag, " dm_we"}, dwe, 1);
        check({tag, " dm_addr"}, da, ea);
        check({tag, " dm_wdata"}, dd, ed);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] vals [6];
        logic [5:0]  fns [5];
        logic [15:0] offs [6];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26};
        offs = '{16'h0000, 16'h0005, 16'hFFFF, 16'h003D, 16'h0010, 16'hFFFD};

        // R1: registers clear after reset (R11: program loaded by port).
        prog[0] = enc_r(6'h20, 5'd3, 5'd1, 5'd2);
        prog[1] = enc_r(6'h25, 5'd4, 5'd31, 5'd17);
        plen = 2;
        boot();
        exp_wr("R1/R11 cleared regs add", 8'd0, 5'd3, 16'h0);
        exp_wr("R1 cleared regs or", 8'd4, 5'd4, 16'h0);

        // R3, R4: sweep operand pairs through every function.
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                prog[0] = enc_i(6'h08, 5'd1, 5'd0, vals[i]);
                prog[1] = enc_i(6'h08, 5'd2, 5'd0, vals[j]);
                for (int k = 0; k < 5; k++)
                    prog[2+k] = enc_r(fns[k], 5'(3+k), 5'd1, 5'd2);
                prog[7] = enc_i(6'h08, 5'd8, 5'd1, vals[j]);
                plen = 8;
                boot();
                exp_wr("R4 addi a", 8'd0, 5'd1, vals[i]);
                exp_wr("R4 addi b", 8'd4, 5'd2, vals[j]);
                for (int k = 0; k < 5; k++)
                    exp_wr("R3 reg op", 8'(8 + 4*k), 5'(3+k), alu_ref(k, vals[i], vals[j]));
                exp_wr("R4 addi rs+imm", 8'd28, 5'd8, vals[i] + vals[j]);
            end
        end

        // R5: register 0 ignores writes and reads zero.
        prog[0] = enc_i(6'h08, 5'd0, 5'd0, 16'h0055);
        prog[1] = enc_r(6'h20, 5'd9, 5'd0, 5'd0);
        prog[2] = enc_i(6'h08, 5'd11, 5'd0, 16'h0007);
        plen = 3;
        boot();
        exp_wr("R5 write to r0 shown", 8'd0, 5'd0, 16'h0055);
        exp_wr("R5 r0 reads zero", 8'd4, 5'd9, 16'h0000);
        exp_wr("R5 r0 as source", 8'd8, 5'd11, 16'h0007);

        // R6, R7: store then load at several offsets, incl. wrap.
        for (int k = 0; k < 6; k++) begin
            logic [15:0] v;
            logic [5:0]  ea;
            v  = 16'hA500 ^ 16'(k * 16'h1111);
            ea = 6'(16'h0003 + offs[k]);
            prog[0] = enc_i(6'h08, 5'd1, 5'd0, 16'h0003);
            prog[1] = enc_i(6'h08, 5'd2, 5'd0, v);
            prog[2] = enc_i(6'h2B, 5'd2, 5'd1, offs[k]);
            prog[3] = enc_i(6'h08, 5'd2, 5'd0, 16'h0000);
            prog[4] = enc_i(6'h23, 5'd12, 5'd1, offs[k]);
            plen = 5;
            boot();
            exp_wr("R6 setup base", 8'd0, 5'd1, 16'h0003);
            exp_wr("R6 setup data", 8'd4, 5'd2, v);
            exp_st("R6 store", 8'd8, ea, v);
            exp_wr("R7 clobber", 8'd12, 5'd2, 16'h0000);
            exp_wr("R7 load", 8'd16, 5'd12, v);
        end

        // R8: absolute jumps, upper target bits dropped.
        prog[0] = enc_i(6'h08, 5'd1, 5'd0, 16'h0001);
        prog[1] = enc_j(26'h45);
        prog[2] = enc_i(6'h08, 5'd1, 5'd0, 16'h0099);
        prog[3] = enc_i(6'h08, 5'd2, 5'd0, 16'h0002);
        prog[4] = enc_i(6'h08, 5'd1, 5'd0, 16'h0088);
        prog[5] = enc_j(26'h3000043);
        plen = 6;
        boot();
        exp_wr("R8 pre", 8'd0, 5'd1, 16'h0001);
        exp_quiet("R8 jump", 8'd4);
        exp_quiet("R8 jump upper bits", 8'd20);
        exp_wr("R8 landed", 8'd12, 5'd2, 16'h0002);

        // R9: taken forward, not taken, taken backward.
        prog[0] = enc_i(6'h08, 5'd1, 5'd0, 16'h0005);
        prog[1] = enc_i(6'h08, 5'd2, 5'd0, 16'h0005);
        prog[2] = enc_i(6'h04, 5'd2, 5'd1, 16'h0003);
        prog[3] = enc_i(6'h08, 5'd3, 5'd0, 16'h0033);
        prog[4] = enc_i(6'h08, 5'd3, 5'd0, 16'h0044);
        prog[5] = enc_i(6'h04, 5'd0, 5'd1, 16'h0007);
        prog[6] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFB);
        plen = 7;
        boot();
        exp_wr("R9 pre a", 8'd0, 5'd1, 16'h0005);
        exp_wr("R9 pre b", 8'd4, 5'd2, 16'h0005);
        exp_quiet("R9 taken fwd", 8'd8);
        exp_quiet("R9 not taken", 8'd20);
        exp_quiet("R9 taken back", 8'd24);
        exp_wr("R9 back target", 8'd4, 5'd2, 16'h0005);

        // R10: unknown opcode and unknown function do nothing.
        prog[0] = enc_i(6'h3F, 5'd1, 5'd0, 16'h1111);
        prog[1] = enc_r(6'h3F, 5'd5, 5'd0, 5'd0);
        prog[2] = enc_r(6'h20, 5'd6, 5'd1, 5'd5);
        plen = 3;
        boot();
        exp_quiet("R10 unknown opcode", 8'd0);
        exp_quiet("R10 unknown funct", 8'd4);
        exp_wr("R10 regs untouched", 8'd8, 5'd6, 16'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule